// File: doc/BRIEF.md
# Dual-Port Hub Memory Map

This block owns the hub address space of a multi-core chip and serves it through two ports. The shared hub port takes byte addresses and sees three regions. The lower half is read/write RAM. The third quarter is a read-only font table. The top quarter holds a boot ROM a quarter of that window in size, which repeats four times across it. The second port belongs to one privileged core. That core treats the whole RAM as its own register and instruction store and addresses it by long word, at full speed and with no hub arbitration.

The core keeps sixteen special-register shadow longs at long addresses 0x1F0 to 0x1FF, which are hub bytes 0x7C0 to 0x7FF. No program is copied when the core is launched. A start request clears those sixteen shadow longs through the core port, then releases the core with its first fetch address, which is the start byte address divided by four.

The byte address width `ADDR_W` sets the size. A value of 16 gives the full 64 KB map with 8192 RAM longs. The default of 12 gives a 4 KB map with 512 RAM longs, which is the smallest size that still holds the shadow block.

Top module: `hub_memmap`

## Requirements
- R1: While reset is held and on the first cycle after it, `hub_ack`, `boot_busy` and `boot_go` are 0.
- R2: A hub request at byte address A with A[ADDR_W-1]=0 reaches RAM long A[ADDR_W-2:2]. The low two address bits are ignored. `hub_ack` is high in the cycle after the request. For a read, `hub_rdata` carries the long in that same cycle.
- R3: On a hub RAM write, `hub_be[k]` enables byte k, which is bits 8k+7 to 8k of the long. Bytes whose enable is 0 keep their old value.
- R4: Hub addresses with the top two bits equal to 10 read font word i = A[ADDR_W-3:2]. The font word is 0xF0A10000 + 259*i, taken modulo 2^32.
- R5: Hub addresses with the top two bits equal to 11 read boot word j = A[ADDR_W-5:2], so all four aliases return the same data. The boot word is 0xB0070000 XOR (j<<8) XOR j.
- R6: A hub write to the font or boot region changes nothing that a later read can see, and it is still acknowledged in the next cycle.
- R7: Core long address N is the same storage as hub bytes 4N to 4N+3. A write on either port is visible on the other. `core_rdata` is valid in the cycle after `core_en`.
- R8: When one port reads a long while the other port writes it in the same cycle, the reader gets the old contents.
- R9: When both ports write the same long in the same cycle, the bytes enabled by `hub_be` take the hub data and the other bytes take the core data.
- R10: An accepted `start_req` raises `boot_busy` for exactly 16 cycles. During those cycles the block writes zero to longs 0x1F0 to 0x1FF and leaves every other long unchanged. In the following cycle it pulses `boot_go` for one cycle, with `boot_pc` equal to `start_addr[ADDR_W-2:2]`.
- R11: While `boot_busy` is high, a new `start_req` is ignored, so neither `boot_pc` nor the pulse count changes. Core-port writes are also discarded during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hub_req | input | 1 | Hub access request, one cycle per access |
| hub_we | input | 1 | Hub access is a write |
| hub_addr | input | ADDR_W | Hub byte address |
| hub_be | input | 4 | Hub per-byte write enables |
| hub_wdata | input | 32 | Hub write data |
| hub_ack | output | 1 | Acknowledge, one cycle after the request |
| hub_rdata | output | 32 | Hub read data, valid with the acknowledge |
| core_en | input | 1 | Core long access enable |
| core_we | input | 1 | Core access is a write |
| core_addr | input | ADDR_W-3 | Core long address |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Core read data, one cycle after the enable |
| start_req | input | 1 | Launch the privileged core |
| start_addr | input | ADDR_W | Long-aligned hub byte start address |
| boot_busy | output | 1 | Shadow clear in progress |
| boot_go | output | 1 | One-cycle release pulse |
| boot_pc | output | ADDR_W-3 | First fetch long address |

## Verification
The bench goes after the places where the two address views meet. The first is the byte-to-long mapping between ports. A slip of one bit would make core and hub see shifted data. The next is folding of the boot window: a wrong index slice would give each alias different words. Byte-enable merging could leak unenabled bytes. Read-first timing matters, because write-first would return new data to the other port. On a same-long collision, the wrong priority would let core bytes overwrite the hub's bytes. The start sequence is checked over the whole RAM. This catches a clear that is one long off, too long or too short. It also catches a clear that can be restarted, or one that lets core writes through.

// File: rtl/hubmap_pkg.sv
package hubmap_pkg;
  typedef enum logic [1:0] {RG_RAM = 2'd0, RG_FONT = 2'd1, RG_BOOT = 2'd2} region_e;

  localparam int SHADOW_BASE  = 'h1F0;
  localparam int SHADOW_LONGS = 16;

  // Font table contents, computed instead of tabulated.
  function automatic logic [31:0] font_word(input logic [31:0] idx);
    return 32'hF0A1_0000 + idx * 32'd259;
  endfunction

  // Boot ROM contents.
  function automatic logic [31:0] boot_word(input logic [31:0] idx);
    return 32'hB007_0000 ^ (idx << 8) ^ idx;
  endfunction
endpackage

// File: rtl/hub_region_dec.sv
module hub_region_dec
  import hubmap_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-4:0] ram_idx,
  output logic [ADDR_W-5:0] font_idx,
  output logic [ADDR_W-7:0] boot_idx
);
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    if (!addr[ADDR_W-1])      region = RG_RAM;
    else if (!addr[ADDR_W-2]) region = RG_FONT;
    else                      region = RG_BOOT;
  end

  assign ram_idx  = addr[ADDR_W-2:2];
  assign font_idx = addr[ADDR_W-3:2];
  // Boot ROM is a quarter of its window, so two more upper bits fold away.
  assign boot_idx = addr[ADDR_W-5:2];
endmodule

// File: rtl/hub_dpram.sv
module hub_dpram #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [3:0]    a_be,
  input  logic [LW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [LW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata
);
  localparam int DEPTH = 1 << LW;
  logic [31:0] mem [DEPTH];

  // Port B updates first and port A after it, so port A's enabled bytes
  // take precedence on a same-long collision. Both reads see the old data.
  always_ff @(posedge clk) begin
    if (b_en) begin
      b_rdata <= mem[b_addr];
      if (b_we) mem[b_addr] <= b_wdata;
    end
    if (a_en) begin
      a_rdata <= mem[a_addr];
      if (a_we) begin
        for (int k = 0; k < 4; k++) begin
          if (a_be[k]) mem[a_addr][8*k +: 8] <= a_wdata[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/shadow_clear.sv
module shadow_clear
  import hubmap_pkg::*;
#(
  parameter int RAM_LW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [RAM_LW-1:0] start_lidx,
  output logic              busy,
  output logic              go,
  output logic [RAM_LW-1:0] pc,
  output logic              clr_we,
  output logic [RAM_LW-1:0] clr_addr
);
  localparam int CW = $clog2(SHADOW_LONGS);
  logic [CW-1:0] cnt;
  logic          last_step;

  assign last_step = (cnt == CW'(SHADOW_LONGS - 1));
  assign clr_we    = busy;
  assign clr_addr  = RAM_LW'(SHADOW_BASE) + RAM_LW'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      go   <= 1'b0;
      cnt  <= '0;
      pc   <= '0;
    end else begin
      go <= 1'b0;
      if (!busy && start_req) begin
        busy <= 1'b1;
        cnt  <= '0;
        pc   <= start_lidx;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          go   <= 1'b1;
        end
      end
    end
  end

  // R10: clearing writes land only inside the shadow block
  a_r10_clear_in_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |-> (clr_addr >= RAM_LW'(SHADOW_BASE)));
  // R10: release follows the busy phase directly
  a_r10_go_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ($past(busy) && !busy));
  // R10: release pulse lasts one cycle
  a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  // R11: a start request during the clear leaves the fetch address alone
  a_r11_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(pc));
endmodule

// File: rtl/hub_memmap.sv
module hub_memmap
  import hubmap_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hub_req,
  input  logic              hub_we,
  input  logic [ADDR_W-1:0] hub_addr,
  input  logic [3:0]        hub_be,
  input  logic [31:0]       hub_wdata,
  output logic              hub_ack,
  output logic [31:0]       hub_rdata,
  input  logic              core_en,
  input  logic              core_we,
  input  logic [ADDR_W-4:0] core_addr,
  input  logic [31:0]       core_wdata,
  output logic [31:0]       core_rdata,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              boot_busy,
  output logic              boot_go,
  output logic [ADDR_W-4:0] boot_pc
);
  localparam int RAM_LW  = ADDR_W - 3;
  localparam int FONT_LW = ADDR_W - 4;
  localparam int BOOT_LW = ADDR_W - 6;

  region_e             region, region_q;
  logic [RAM_LW-1:0]   ram_idx;
  logic [FONT_LW-1:0]  font_idx, font_idx_q;
  logic [BOOT_LW-1:0]  boot_idx, boot_idx_q;
  logic                ack_q;
  logic                a_en;
  logic [31:0]         a_rdata;
  logic                b_en, b_we;
  logic [RAM_LW-1:0]   b_addr;
  logic [31:0]         b_wdata;
  logic                clr_we;
  logic [RAM_LW-1:0]   clr_addr;
  logic                unused_start;

  assign unused_start = ^{start_addr[ADDR_W-1], start_addr[1:0]};

  hub_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(hub_addr), .region(region), .ram_idx(ram_idx),
    .font_idx(font_idx), .boot_idx(boot_idx)
  );

  shadow_clear #(.RAM_LW(RAM_LW)) u_clr (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .start_lidx(start_addr[ADDR_W-2:2]), .busy(boot_busy), .go(boot_go),
    .pc(boot_pc), .clr_we(clr_we), .clr_addr(clr_addr)
  );

  assign a_en = hub_req && (region == RG_RAM);

  // The clear sequence owns the core port while it runs.
  always_comb begin
    if (clr_we) begin
      b_en = 1'b1; b_we = 1'b1; b_addr = clr_addr; b_wdata = '0;
    end else begin
      b_en = core_en; b_we = core_we; b_addr = core_addr; b_wdata = core_wdata;
    end
  end

  hub_dpram #(.LW(RAM_LW)) u_ram (
    .clk(clk),
    .a_en(a_en), .a_we(hub_we), .a_be(hub_be), .a_addr(ram_idx),
    .a_wdata(hub_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(core_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      region_q   <= RG_RAM;
      font_idx_q <= '0;
      boot_idx_q <= '0;
    end else begin
      ack_q <= hub_req;
      if (hub_req) begin
        region_q   <= region;
        font_idx_q <= font_idx;
        boot_idx_q <= boot_idx;
      end
    end
  end

  assign hub_ack = ack_q;

  always_comb begin
    case (region_q)
      RG_FONT: hub_rdata = font_word(32'(font_idx_q));
      RG_BOOT: hub_rdata = boot_word(32'(boot_idx_q));
      default: hub_rdata = a_rdata;
    endcase
  end

  // R2, R6: every hub request is acknowledged in the next cycle
  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    hub_req |=> hub_ack);
  // R2: no acknowledge without a request
  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !hub_req |=> !hub_ack);
  // R11: the core's own write does not reach the RAM during the clear
  a_r11_core_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy |-> (b_wdata == 32'd0));
endmodule

// File: tb/tb_hub_memmap.sv
module tb_hub_memmap;
  localparam int AW = 12;
  localparam int NL = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hub_req = 0, hub_we = 0;
  logic [AW-1:0] hub_addr = '0;
  logic [3:0] hub_be = '0;
  logic [31:0] hub_wdata = '0;
  logic hub_ack;
  logic [31:0] hub_rdata;
  logic core_en = 0, core_we = 0;
  logic [AW-4:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic [31:0] core_rdata;
  logic start_req = 0;
  logic [AW-1:0] start_addr = '0;
  logic boot_busy, boot_go;
  logic [AW-4:0] boot_pc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hub_memmap #(.ADDR_W(AW)) dut (.*);

  function automatic logic [31:0] pat_a(input int i);  return 32'h1357_0000 + i * 32'h0001_0003; endfunction
  function automatic logic [31:0] pat_b(input int i);  return ~(32'h00C0_FFEE ^ (i << 12) ^ i); endfunction
  function automatic logic [31:0] pat_c(input int i);  return 32'h5A00_0000 | (i * 7); endfunction
  function automatic logic [31:0] font_exp(input int i); return 32'hF0A1_0000 + 32'(i) * 32'd259; endfunction
  function automatic logic [31:0] boot_exp(input int j); return 32'hB007_0000 ^ (32'(j) << 8) ^ 32'(j); endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic hub_op(input logic we, input logic [AW-1:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output logic ack);
    @(negedge clk);
    hub_req = 1; hub_we = we; hub_addr = a; hub_be = be; hub_wdata = wd;
    @(negedge clk);
    hub_req = 0; hub_we = 0;
    rd = hub_rdata; ack = hub_ack;
  endtask

  task automatic core_op(input logic we, input int a, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    core_en = 1; core_we = we; core_addr = (AW-3)'(a); core_wdata = wd;
    @(negedge clk);
    core_en = 0; core_we = 0;
    rd = core_rdata;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic ack;
    int ack_bad;
    int nbusy, ngo;
    logic [AW-4:0] pc_seen;
    logic [31:0] exp;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ack", 32'(hub_ack), 0);
    chk("R1 busy", 32'(boot_busy), 0);
    chk("R1 go", 32'(boot_go), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 32'({hub_ack, boot_busy, boot_go}), 0);

    // R2: hub write/read sweep over every RAM long
    ack_bad = 0;
    for (int i = 0; i < NL; i++) begin
      hub_op(1, AW'(4 * i), 4'hF, pat_a(i), rd, ack);
      if (!ack) ack_bad++;
    end
    for (int i = 0; i < NL; i++) begin
      hub_op(0, AW'(4 * i + (i % 4)), 4'h0, 0, rd, ack);
      if (!ack) ack_bad++;
      chk("R2 hub readback", rd, pat_a(i));
    end
    chk("R2 ack count", 32'(ack_bad), 0);

    // R7: core sees hub data at long N, then hub sees core data
    for (int i = 0; i < NL; i++) begin
      core_op(0, i, 0, rd);
      chk("R7 core reads hub data", rd, pat_a(i));
    end
    for (int i = 0; i < NL; i++) core_op(1, i, pat_b(i), rd);
    for (int i = 0; i < NL; i++) begin
      hub_op(0, AW'(4 * i + 3 - (i % 4)), 4'h0, 0, rd, ack);
      chk("R7 hub reads core data", rd, pat_b(i));
    end

    // R3: every byte enable pattern
    for (int m = 0; m < 16; m++) begin
      core_op(1, 7, 32'h1122_3344, rd);
      hub_op(1, AW'(28), 4'(m), 32'hAABB_CCDD, rd, ack);
      exp = 32'h1122_3344;
      for (int k = 0; k < 4; k++) if (m[k]) exp[8*k +: 8] = 8'(32'hAABB_CCDD >> (8 * k));
      core_op(0, 7, 0, rd);
      chk("R3 byte enables", rd, exp);
    end

    // R4: font sweep
    for (int i = 0; i < 256; i++) begin
      hub_op(0, AW'(12'h800 + 4 * i), 4'h0, 0, rd, ack);
      chk("R4 font word", rd, font_exp(i));
    end

    // R5: boot ROM, all four aliases
    for (int a = 0; a < 4; a++)
      for (int j = 0; j < 64; j++) begin
        hub_op(0, AW'(12'hC00 + 256 * a + 4 * j + a), 4'h0, 0, rd, ack);
        chk("R5 boot alias", rd, boot_exp(j));
      end

    // R6: ROM writes ignored but acknowledged
    hub_op(1, AW'(12'h844), 4'hF, 32'hDEAD_BEEF, rd, ack);
    chk("R6 font write ack", 32'(ack), 1);
    hub_op(0, AW'(12'h844), 4'h0, 0, rd, ack);
    chk("R6 font unchanged", rd, font_exp(17));
    hub_op(1, AW'(12'hF08), 4'hF, 32'hDEAD_BEEF, rd, ack);
    chk("R6 boot write ack", 32'(ack), 1);
    hub_op(0, AW'(12'hC08), 4'h0, 0, rd, ack);
    chk("R6 boot unchanged", rd, boot_exp(2));
    hub_op(0, AW'(12'h044), 4'h0, 0, rd, ack);
    chk("R6 ram untouched", rd, pat_b(17));

    // R8: hub writes while core reads the same long
    @(negedge clk);
    hub_req = 1; hub_we = 1; hub_addr = AW'(40); hub_be = 4'hF; hub_wdata = 32'h0BAD_F00D;
    core_en = 1; core_we = 0; core_addr = 10;
    @(negedge clk);
    hub_req = 0; hub_we = 0; core_en = 0;
    chk("R8 core read-first", core_rdata, pat_b(10));
    // R8: core writes while hub reads the same long
    @(negedge clk);
    hub_req = 1; hub_we = 0; hub_addr = AW'(44);
    core_en = 1; core_we = 1; core_addr = 11; core_wdata = 32'h7777_1111;
    @(negedge clk);
    hub_req = 0; core_en = 0; core_we = 0;
    chk("R8 hub read-first", hub_rdata, pat_b(11));
    core_op(0, 11, 0, rd);
    chk("R8 core write landed", rd, 32'h7777_1111);

    // R9: same-long collision
    @(negedge clk);
    hub_req = 1; hub_we = 1; hub_addr = AW'(48); hub_be = 4'b0101; hub_wdata = 32'hA1A2_A3A4;
    core_en = 1; core_we = 1; core_addr = 12; core_wdata = 32'hC1C2_C3C4;
    @(negedge clk);
    hub_req = 0; hub_we = 0; core_en = 0; core_we = 0;
    hub_op(0, AW'(48), 4'h0, 0, rd, ack);
    chk("R9 collision merge", rd, 32'hC1A2_C3A4);

    // R10, R11: start sequence
    for (int i = 0; i < NL; i++) core_op(1, i, pat_c(i), rd);
    @(negedge clk);
    start_req = 1; start_addr = AW'(12'h124);
    nbusy = 0; ngo = 0; pc_seen = '0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (boot_busy) nbusy++;
      if (boot_go) begin ngo++; pc_seen = boot_pc; end
      start_req = 0; core_en = 0; core_we = 0;
      if (cyc == 3) begin
        start_req = 1; start_addr = AW'(12'h3F0);
        core_en = 1; core_we = 1; core_addr = 5; core_wdata = 32'h0000_DEAD;
      end
    end
    chk("R10 busy length", 32'(nbusy), 16);
    chk("R11 single release", 32'(ngo), 1);
    chk("R10 R11 start pc", 32'(pc_seen), 32'h49);
    for (int i = 0; i < NL; i++) begin
      hub_op(0, AW'(4 * i), 4'h0, 0, rd, ack);
      if (i >= 'h1F0) chk("R10 shadow cleared", rd, 0);
      else chk("R10 R11 other longs kept", rd, pat_c(i));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule